// File: doc/BRIEF.md
# Memory Micro-op Port Allocator

This block sits between a core's queue of pending memory micro-ops and its address-generation ports. Each cycle it looks at a window of the oldest queued ops, every one marked as a load or a store, with an address form (plain base plus displacement, or with an index register) and an access width (128 or 256 bits). It assigns the ops to ports, strictly oldest first, and reports how many ops leave the head of the queue.

A build-time switch picks between two port layouts. In split mode only the two general ports (port 0 and port 1) exist. They carry loads and stores alike. The data path allows either two loads or one load plus one store per cycle. A 256-bit access keeps its data lane busy for the following cycle too, although the port that computed its address is free again at once. In dedicated-store mode a third port (port 2) is added that takes only stores without an index register. Two loads and one store can then leave per cycle, and width costs nothing extra. Indexed stores must use a general port and so take a slot a load could have used.

Each port has a valid/ready pair: an op is placed on a port only when that port's ready is high. The block also reports, per cycle, how many loads and how many stores it issued.

Top module: `memop_port_alloc`

## Requirements
- R1: While reset is asserted, and until the second rising clock edge after it is released, no port valid is high and the pop count is 0.
- R2: Ops are granted strictly in queue order: the granted ops are always a leading run of the valid window, and once an op cannot be placed no younger op is granted that cycle. The pop count equals the number of granted ops.
- R3: A port is driven valid only while its ready input is high, and it carries at most one op per cycle.
- R4: In split mode a cycle issues at most two ops on ports 0 and 1 only, with at most one store (two loads, or one load and one store). At most one store issues per cycle in either mode.
- R5: In split mode each 256-bit load issued in cycle t holds one of the two read lanes in cycle t+1, so cycle t+1 issues at most two minus that many loads.
- R6: In split mode a 256-bit store issued in cycle t blocks any store in cycle t+1, while loads may still issue in cycle t+1.
- R7: In split mode, with all ports ready, a repeating stream of 256-bit load, 256-bit store, 256-bit load issues one load every cycle and one store every second cycle. This is the data volume of two 128-bit loads and one 128-bit store per cycle.
- R8: In dedicated-store mode, with all ports ready, a cycle can issue two loads and one store, and 256-bit width never delays a later op.
- R9: Port 2 exists only in dedicated-store mode and carries only stores whose address has no index register.
- R10: An indexed store in dedicated-store mode goes to port 0 or port 1 and uses up that port for younger loads.
- R11: A non-indexed store in dedicated-store mode goes to port 2 when port 2 is ready and unused; otherwise it takes a general port.
- R12: The issued-load and issued-store outputs equal the number of loads and stores granted in the same cycle.
- R13: A load, or a store that goes to a general port, takes port 0 if port 0 is ready and still unused this cycle, otherwise port 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_vld_i | input | WIN | Window slot holds an op; slot 0 is the oldest, valid slots are contiguous from 0 |
| slot_store_i | input | WIN | 1 = store, 0 = load |
| slot_idx_i | input | WIN | 1 = address uses an index register |
| slot_wide_i | input | WIN | 1 = 256-bit access, 0 = 128-bit |
| slot_tag_i | input | WIN*TAGW | Per-slot op tag, slot k at bits k*TAGW upward |
| port_rdy_i | input | 3 | Port ready, bit p for port p |
| port_vld_o | output | 3 | Port carries a granted op this cycle |
| port_store_o | output | 3 | Granted op on port p is a store |
| port_idx_o | output | 3 | Granted op on port p uses an index register |
| port_wide_o | output | 3 | Granted op on port p is 256-bit |
| port_tag_o | output | 3*TAGW | Tag of the op on port p, at bits p*TAGW upward |
| pop_o | output | clog2(WIN+1) | Number of ops leaving the queue head |
| issued_ld_o | output | 2 | Loads issued this cycle |
| issued_st_o | output | 2 | Stores issued this cycle |

## Verification
The hardest state to reach is a split-mode cycle in which lanes held by wide ops from the previous cycle stall an older op, while a younger op behind it would find a free lane. The allocator must then still grant nothing past the stalled op. Random traffic seldom lines up a wide op, a blocked store and a ready younger load in that order. So directed queues build the exact sequences: wide store then narrow store then load, wide load pairs then a narrow load, and the repeating wide load/store/load stream. Long random runs with random ready gaps and shortened windows then cover the remaining mixes against a bench model in both modes.

// File: rtl/memop_alloc_pkg.sv
package memop_alloc_pkg;

  localparam int NPORT = 3;

  typedef enum logic [1:0] {
    PORT_G0 = 2'd0,
    PORT_G1 = 2'd1,
    PORT_S  = 2'd2
  } port_e;

  // Resources still free while walking the window oldest to youngest.
  typedef struct packed {
    logic [NPORT-1:0] used;
    logic [1:0]       ld_free;
    logic             st_free;
  } place_t;

endpackage

// File: rtl/memop_rst_sync.sv
module memop_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_d;
  logic [1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/memop_lane_hold.sv
module memop_lane_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] wide_ld_i,
  input  logic       wide_st_i,
  output logic [1:0] held_ld_o,
  output logic       held_st_o
);

  logic [1:0] ld_d;
  logic [1:0] ld_q;
  logic       st_d;
  logic       st_q;

  // A wide access keeps its lane for exactly one more cycle.
  always_comb begin
    ld_d = en_i ? wide_ld_i : 2'd0;
    st_d = en_i & wide_st_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q <= 2'd0;
      st_q <= 1'b0;
    end else begin
      ld_q <= ld_d;
      st_q <= st_d;
    end
  end

  assign held_ld_o = ld_q;
  assign held_st_o = st_q;

endmodule

// File: rtl/memop_slot_place.sv
module memop_slot_place
  import memop_alloc_pkg::*;
#(
  parameter bit DED_STORE = 1'b0
) (
  input  place_t           st_i,
  input  logic             prev_ok_i,
  input  logic             vld_i,
  input  logic             store_i,
  input  logic             idx_i,
  input  logic [NPORT-1:0] rdy_i,
  output logic             grant_o,
  output port_e            port_o,
  output place_t           st_o
);

  logic gen0_free;
  logic gen1_free;
  logic st_port_ok;
  logic can_place;

  always_comb begin
    gen0_free  = rdy_i[0] & ~st_i.used[0];
    gen1_free  = rdy_i[1] & ~st_i.used[1];
    st_port_ok = DED_STORE & rdy_i[2] & ~st_i.used[2] & ~idx_i;

    can_place = 1'b0;
    port_o    = PORT_G0;
    if (store_i) begin
      if (st_port_ok) begin
        can_place = st_i.st_free;
        port_o    = PORT_S;
      end else if (gen0_free) begin
        can_place = st_i.st_free;
        port_o    = PORT_G0;
      end else if (gen1_free) begin
        can_place = st_i.st_free;
        port_o    = PORT_G1;
      end
    end else if (st_i.ld_free != 2'd0) begin
      if (gen0_free) begin
        can_place = 1'b1;
        port_o    = PORT_G0;
      end else if (gen1_free) begin
        can_place = 1'b1;
        port_o    = PORT_G1;
      end
    end

    grant_o = prev_ok_i & vld_i & can_place;

    st_o = st_i;
    if (grant_o) begin
      st_o.used[port_o] = 1'b1;
      if (store_i) begin
        st_o.st_free = 1'b0;
      end else begin
        st_o.ld_free = st_i.ld_free - 2'd1;
      end
    end
  end

endmodule

// File: rtl/memop_port_alloc.sv
module memop_port_alloc
  import memop_alloc_pkg::*;
#(
  parameter int WIN       = 4,
  parameter int TAGW      = 6,
  parameter bit DED_STORE = 1'b0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WIN-1:0]             slot_vld_i,
  input  logic [WIN-1:0]             slot_store_i,
  input  logic [WIN-1:0]             slot_idx_i,
  input  logic [WIN-1:0]             slot_wide_i,
  input  logic [WIN*TAGW-1:0]        slot_tag_i,
  input  logic [NPORT-1:0]           port_rdy_i,
  output logic [NPORT-1:0]           port_vld_o,
  output logic [NPORT-1:0]           port_store_o,
  output logic [NPORT-1:0]           port_idx_o,
  output logic [NPORT-1:0]           port_wide_o,
  output logic [NPORT*TAGW-1:0]      port_tag_o,
  output logic [$clog2(WIN+1)-1:0]   pop_o,
  output logic [1:0]                 issued_ld_o,
  output logic [1:0]                 issued_st_o
);

  localparam int POPW = $clog2(WIN+1);

  logic       active;
  logic [1:0] held_ld;
  logic       held_st;
  logic [1:0] wide_ld;
  logic       wide_st;
  place_t     seed;
  place_t     after [WIN];
  logic [WIN-1:0] grant;
  port_e      slot_port [WIN];

  memop_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (active)
  );

  memop_lane_hold u_lane_hold (
    .clk_i     (clk_i),
    .rst_ni    (active),
    .en_i      (!DED_STORE),
    .wide_ld_i (wide_ld),
    .wide_st_i (wide_st),
    .held_ld_o (held_ld),
    .held_st_o (held_st)
  );

  always_comb begin
    seed.used    = '0;
    seed.ld_free = DED_STORE ? 2'd2 : 2'd2 - held_ld;
    seed.st_free = DED_STORE ? 1'b1 : ~held_st;
  end

  for (genvar i = 0; i < WIN; i++) begin : g_slot
    if (i == 0) begin : g_head
      memop_slot_place #(.DED_STORE(DED_STORE)) u_place (
        .st_i      (seed),
        .prev_ok_i (active),
        .vld_i     (slot_vld_i[i]),
        .store_i   (slot_store_i[i]),
        .idx_i     (slot_idx_i[i]),
        .rdy_i     (port_rdy_i),
        .grant_o   (grant[i]),
        .port_o    (slot_port[i]),
        .st_o      (after[i])
      );
    end else begin : g_tail
      memop_slot_place #(.DED_STORE(DED_STORE)) u_place (
        .st_i      (after[i-1]),
        .prev_ok_i (grant[i-1]),
        .vld_i     (slot_vld_i[i]),
        .store_i   (slot_store_i[i]),
        .idx_i     (slot_idx_i[i]),
        .rdy_i     (port_rdy_i),
        .grant_o   (grant[i]),
        .port_o    (slot_port[i]),
        .st_o      (after[i])
      );
    end
  end

  // Route each granted slot onto the port it claimed.
  always_comb begin
    port_vld_o   = '0;
    port_store_o = '0;
    port_idx_o   = '0;
    port_wide_o  = '0;
    port_tag_o   = '0;
    for (int i = 0; i < WIN; i++) begin
      if (grant[i]) begin
        port_vld_o[slot_port[i]]   = 1'b1;
        port_store_o[slot_port[i]] = slot_store_i[i];
        port_idx_o[slot_port[i]]   = slot_idx_i[i];
        port_wide_o[slot_port[i]]  = slot_wide_i[i];
        port_tag_o[int'(slot_port[i])*TAGW +: TAGW] = slot_tag_i[i*TAGW +: TAGW];
      end
    end
  end

  always_comb begin
    wide_ld = 2'd0;
    wide_st = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      if (grant[i] && slot_wide_i[i]) begin
        if (slot_store_i[i]) begin
          wide_st = 1'b1;
        end else begin
          wide_ld = wide_ld + 2'd1;
        end
      end
    end
  end

  // Counts fall out of the resources consumed along the chain.
  always_comb begin
    pop_o       = POPW'($countones(after[WIN-1].used));
    issued_ld_o = seed.ld_free - after[WIN-1].ld_free;
    issued_st_o = {1'b0, seed.st_free & ~after[WIN-1].st_free};
  end

endmodule

// File: rtl/memop_alloc_chk.sv
module memop_alloc_chk #(
  parameter int WIN       = 4,
  parameter bit DED_STORE = 1'b0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [2:0]               port_rdy_i,
  input logic [2:0]               port_vld_o,
  input logic [2:0]               port_store_o,
  input logic [2:0]               port_idx_o,
  input logic [2:0]               port_wide_o,
  input logic [$clog2(WIN+1)-1:0] pop_o,
  input logic [1:0]               issued_ld_o,
  input logic [1:0]               issued_st_o
);

  logic [2:0] ld_on;
  logic [2:0] st_on;
  int         n_wide_ld;
  logic       any_wide_st;

  always_comb begin
    ld_on       = port_vld_o & ~port_store_o;
    st_on       = port_vld_o & port_store_o;
    n_wide_ld   = DED_STORE ? 0 : $countones(ld_on & port_wide_o);
    any_wide_st = !DED_STORE && ((st_on & port_wide_o) != 3'b000);
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (port_vld_o == 3'b000 && pop_o == '0));

  a_r3_ready_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_vld_o & ~port_rdy_i) == 3'b000);

  a_r2_pop_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_o) == $countones(port_vld_o));

  a_r4_one_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_on) <= 1);

  a_r12_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(issued_ld_o) == $countones(ld_on) && int'(issued_st_o) == $countones(st_on));

  if (!DED_STORE) begin : g_split
    a_r4_two_general: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(port_vld_o) <= 2 && !port_vld_o[2]);

    a_r5_read_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ld_on) + $past(n_wide_ld) <= 2);

    a_r6_store_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(any_wide_st) |-> st_on == 3'b000);
  end else begin : g_ded
    a_r9_store_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_vld_o[2] |-> (port_store_o[2] && !port_idx_o[2]));

    a_r8_load_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ld_on) <= 2 && n_wide_ld == 0 && !any_wide_st);
  end

endmodule

bind memop_port_alloc memop_alloc_chk #(
  .WIN       (WIN),
  .DED_STORE (DED_STORE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .port_rdy_i   (port_rdy_i),
  .port_vld_o   (port_vld_o),
  .port_store_o (port_store_o),
  .port_idx_o   (port_idx_o),
  .port_wide_o  (port_wide_o),
  .pop_o        (pop_o),
  .issued_ld_o  (issued_ld_o),
  .issued_st_o  (issued_st_o)
);

// File: tb/tb_memop_port_alloc.sv
`timescale 1ns/1ps
module tb_memop_port_alloc;

  localparam int WIN  = 4;
  localparam int TAGW = 6;
  localparam int QN   = 1024;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [WIN-1:0]      s_vld [2];
  logic [WIN-1:0]      s_st  [2];
  logic [WIN-1:0]      s_ix  [2];
  logic [WIN-1:0]      s_wd  [2];
  logic [WIN*TAGW-1:0] s_tag [2];
  logic [2:0]          rdy   [2];
  logic [2:0]          o_vld [2];
  logic [2:0]          o_st  [2];
  logic [2:0]          o_ix  [2];
  logic [2:0]          o_wd  [2];
  logic [3*TAGW-1:0]   o_tag [2];
  logic [2:0]          o_pop [2];
  logic [1:0]          o_ld  [2];
  logic [1:0]          o_sto [2];

  memop_port_alloc #(.WIN(WIN), .TAGW(TAGW), .DED_STORE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_vld_i(s_vld[0]), .slot_store_i(s_st[0]), .slot_idx_i(s_ix[0]),
    .slot_wide_i(s_wd[0]), .slot_tag_i(s_tag[0]), .port_rdy_i(rdy[0]),
    .port_vld_o(o_vld[0]), .port_store_o(o_st[0]), .port_idx_o(o_ix[0]),
    .port_wide_o(o_wd[0]), .port_tag_o(o_tag[0]), .pop_o(o_pop[0]),
    .issued_ld_o(o_ld[0]), .issued_st_o(o_sto[0])
  );

  memop_port_alloc #(.WIN(WIN), .TAGW(TAGW), .DED_STORE(1'b1)) dut_ded (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_vld_i(s_vld[1]), .slot_store_i(s_st[1]), .slot_idx_i(s_ix[1]),
    .slot_wide_i(s_wd[1]), .slot_tag_i(s_tag[1]), .port_rdy_i(rdy[1]),
    .port_vld_o(o_vld[1]), .port_store_o(o_st[1]), .port_idx_o(o_ix[1]),
    .port_wide_o(o_wd[1]), .port_tag_o(o_tag[1]), .pop_o(o_pop[1]),
    .issued_ld_o(o_ld[1]), .issued_st_o(o_sto[1])
  );

  bit q_st [2][QN];
  bit q_ix [2][QN];
  bit q_wd [2][QN];
  int hd [2];
  int tl [2];
  int vis [2];
  int hl [2];
  bit hs [2];
  int frc [2];
  bit rand_on;
  int nchk = 0;
  int nfail = 0;
  int lp [2];
  int lld [2];
  int lsto [2];
  logic [2:0] lvld [2];
  logic [2:0] lstp [2];

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(int m, bit st, bit ix, bit wd);
    q_st[m][tl[m] % QN] = st;
    q_ix[m][tl[m] % QN] = ix;
    q_wd[m][tl[m] % QN] = wd;
    tl[m]++;
  endtask

  task automatic drive();
    for (int m = 0; m < 2; m++) begin
      if (rand_on) begin
        while (tl[m] - hd[m] < WIN)
          push(m, ($urandom % 10) < 4, $urandom % 2, $urandom % 2);
      end
      vis[m] = (tl[m] - hd[m] < WIN) ? tl[m] - hd[m] : WIN;
      if (rand_on && ($urandom % 8) == 0) vis[m] = $urandom % (vis[m] + 1);
      if (frc[m] >= 0) rdy[m] = 3'(frc[m]);
      else if (rand_on) rdy[m] = {3{1'b0}} | {($urandom % 5) != 0, ($urandom % 5) != 0, ($urandom % 5) != 0};
      else rdy[m] = 3'b111;
      for (int k = 0; k < WIN; k++) begin
        int ix;
        ix = (hd[m] + k) % QN;
        s_vld[m][k] = (k < vis[m]);
        s_st[m][k]  = q_st[m][ix];
        s_ix[m][k]  = q_ix[m][ix];
        s_wd[m][k]  = q_wd[m][ix];
        s_tag[m][k*TAGW +: TAGW] = TAGW'(ix);
      end
    end
  endtask

  // One cycle: drive after the falling edge, predict and compare before the rising edge.
  task automatic step();
    @(negedge clk);
    drive();
    #1;
    for (int m = 0; m < 2; m++) begin
      int avl, epop, eld, est, ewl;
      bit sok, ews;
      bit [2:0] used;
      int eport [WIN];
      bit [2:0] ev, es;
      int etag [3];
      avl = (m == 1) ? 2 : 2 - hl[m];
      sok = (m == 1) ? 1'b1 : !hs[m];
      used = 3'b000; epop = 0; eld = 0; est = 0; ewl = 0; ews = 1'b0;
      for (int k = 0; k < vis[m]; k++) begin
        int ix, p;
        ix = (hd[m] + k) % QN;
        p = -1;
        if (q_st[m][ix]) begin
          if (sok) begin
            if (m == 1 && rdy[m][2] && !used[2] && !q_ix[m][ix]) p = 2;
            else if (rdy[m][0] && !used[0]) p = 0;
            else if (rdy[m][1] && !used[1]) p = 1;
          end
        end else if (avl > 0) begin
          if (rdy[m][0] && !used[0]) p = 0;
          else if (rdy[m][1] && !used[1]) p = 1;
        end
        if (p < 0) break;
        used[p] = 1'b1;
        eport[k] = p;
        epop++;
        if (q_st[m][ix]) begin
          sok = 1'b0; est++;
          if (q_wd[m][ix]) ews = 1'b1;
        end else begin
          avl--; eld++;
          if (q_wd[m][ix]) ewl++;
        end
      end
      ev = 3'b000; es = 3'b000;
      for (int p = 0; p < 3; p++) etag[p] = 0;
      for (int k = 0; k < epop; k++) begin
        int ix;
        ix = (hd[m] + k) % QN;
        ev[eport[k]] = 1'b1;
        es[eport[k]] = q_st[m][ix];
        etag[eport[k]] = ix % (1 << TAGW);
      end
      chk($sformatf("R2 pop mode%0d", m), int'(o_pop[m]), epop);
      chk($sformatf("R12 loads mode%0d", m), int'(o_ld[m]), eld);
      chk($sformatf("R12 stores mode%0d", m), int'(o_sto[m]), est);
      for (int p = 0; p < 3; p++) begin
        chk($sformatf("R3/R9/R11/R13 port%0d valid mode%0d", p, m), int'(o_vld[m][p]), int'(ev[p]));
        if (ev[p]) begin
          chk($sformatf("R10/R13 port%0d tag mode%0d", p, m), int'(o_tag[m][p*TAGW +: TAGW]), etag[p]);
          chk($sformatf("R10 port%0d kind mode%0d", p, m), int'(o_st[m][p]), int'(es[p]));
        end
      end
      lp[m] = int'(o_pop[m]); lld[m] = int'(o_ld[m]); lsto[m] = int'(o_sto[m]);
      lvld[m] = o_vld[m]; lstp[m] = o_st[m];
      hd[m] += epop;
      if (m == 0) begin
        hl[m] = ewl;
        hs[m] = ews;
      end
    end
  endtask

  task automatic prep();
    rand_on = 1'b0;
    for (int m = 0; m < 2; m++) begin
      hd[m] = tl[m];
      frc[m] = -1;
    end
    step();
    step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int sld, sst;
    for (int m = 0; m < 2; m++) begin
      hd[m] = 0; tl[m] = 0; hl[m] = 0; hs[m] = 1'b0; frc[m] = -1;
    end
    void'($urandom(32'd7321));
    rand_on = 1'b1;
    rst_n = 1'b0;
    // R1: in reset with ops offered
    repeat (3) begin
      @(negedge clk);
      drive();
      #1;
      for (int m = 0; m < 2; m++) begin
        chk("R1 reset valid", int'(o_vld[m]), 0);
        chk("R1 reset pop", int'(o_pop[m]), 0);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    drive();
    #1;
    for (int m = 0; m < 2; m++) chk("R1 release cycle0 pop", int'(o_pop[m]), 0);
    @(negedge clk);
    drive();
    #1;
    for (int m = 0; m < 2; m++) chk("R1 release cycle1 pop", int'(o_pop[m]), 0);

    // Random traffic, both modes
    repeat (4000) step();

    // R7: split, wide load/store/load stream
    prep();
    repeat (12) begin
      push(0, 0, 0, 1); push(0, 1, 0, 1); push(0, 0, 1, 1);
    end
    sld = 0; sst = 0;
    for (int c = 0; c < 16; c++) begin
      step();
      sld += lld[0];
      sst += lsto[0];
      chk("R7 alternating pop", lp[0], (c % 2 == 0) ? 2 : 1);
    end
    chk("R7 load units", 2 * sld, 32);
    chk("R7 store units", 2 * sst, 16);

    // R6 and R2: wide store blocks next store; younger load waits behind it
    prep();
    push(0, 1, 0, 1); push(0, 1, 0, 0); push(0, 0, 0, 0);
    step(); chk("R6 wide store alone", lp[0], 1);
    step(); chk("R6 R2 store lane held, younger load waits", lp[0], 0);
    step(); chk("R6 store then load", lp[0], 2);

    // R6: loads still issue while the store lane is held
    prep();
    push(0, 1, 0, 1); push(0, 0, 0, 0); push(0, 0, 0, 0);
    step(); chk("R6 wide store plus load", lp[0], 2);
    step(); chk("R6 load during store hold", lld[0], 1);

    // R5: two wide loads hold both read lanes
    prep();
    push(0, 0, 0, 1); push(0, 0, 0, 1); push(0, 0, 0, 0);
    step(); chk("R5 two wide loads", lp[0], 2);
    step(); chk("R5 lanes held", lp[0], 0);
    step(); chk("R5 lanes back", lp[0], 1);

    // R4: split limits
    prep();
    push(0, 0, 0, 0); push(0, 1, 0, 0); push(0, 1, 0, 0);
    step(); chk("R4 load plus store", lp[0], 2);
    step(); chk("R4 second store next cycle", lsto[0], 1);
    prep();
    push(0, 0, 0, 0); push(0, 0, 0, 0); push(0, 0, 0, 0);
    step(); chk("R4 two loads", lp[0], 2);
    chk("R4 port2 unused in split", int'(lvld[0][2]), 0);

    // R13: port 0 not ready, load goes to port 1
    prep();
    frc[0] = 3'b110;
    push(0, 0, 0, 0);
    step(); chk("R13 load to port1", int'(lvld[0]), 3'b010);

    // R3: only port 0 ready
    prep();
    frc[0] = 3'b001;
    push(0, 1, 0, 0); push(0, 0, 0, 0);
    step(); chk("R3 one ready port", lp[0], 1);
    chk("R3 port0 only", int'(lvld[0]), 3'b001);

    // R8: dedicated mode, two wide loads and a wide store per cycle
    prep();
    repeat (8) begin
      push(1, 0, 1, 1); push(1, 0, 0, 1); push(1, 1, 0, 1);
    end
    repeat (8) begin
      step();
      chk("R8 pop three", lp[1], 3);
      chk("R8 all ports", int'(lvld[1]), 3'b111);
    end

    // R10: indexed store takes a general port from a load
    prep();
    push(1, 1, 1, 0); push(1, 0, 0, 0); push(1, 0, 0, 0);
    step(); chk("R10 indexed store pop", lp[1], 2);
    chk("R10 store on port0", int'(lstp[1]), 3'b001);
    chk("R10 port2 idle", int'(lvld[1]), 3'b011);

    // R11: store port preferred; general port when it is busy
    prep();
    frc[1] = 3'b011;
    push(1, 1, 0, 0);
    step(); chk("R11 fallback to port0", int'(lvld[1]), 3'b001);
    frc[1] = 3'b111;
    push(1, 1, 0, 0);
    step(); chk("R11 store port chosen", int'(lvld[1]), 3'b100);
    push(1, 0, 0, 0); push(1, 1, 0, 0); push(1, 0, 0, 0);
    step(); chk("R11 R9 full cycle", int'(lvld[1]), 3'b111);
    chk("R9 port2 store", int'(lstp[1]), 3'b100);

    summary();
    $finish;
  end

endmodule